// File: doc/BRIEF.md
# Asynchronous Input Conditioner

This block takes a vector of digital lines that toggle with no relation to the local clock and turns each one into clean, clock-aligned signals. Every line first passes through a chain of flip-flops that settles metastability. It then goes through a deglitch filter that accepts a new level only once that level has held for a set number of consecutive clock cycles.

From the filtered level, each line produces three outputs. The first is the level itself. The second is a strobe exactly one cycle wide on the chosen edge (rising or falling, picked by a parameter). The third is a stretched strobe that stays high for a set number of cycles and restarts when a new strobe arrives while it is still high.

Typical uses are buttons, trigger inputs, and external status lines that feed logic in a single clock domain. All lines are handled independently and share no state.

Top module: `async_in_cond`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three outputs are zero after that edge, whatever `raw_i` does. After reset the filtered level starts at 0, so a line that stays at 0 produces no strobe.
- R2: When a raw line changes and then holds, `level_o` for that line takes the new value exactly SYNC_STAGES + FILT_LEN clock edges after the change.
- R3: A raw excursion that lasts fewer than FILT_LEN cycles changes neither `level_o` nor `pulse_o`.
- R4: If the synchronized value reverts before FILT_LEN consecutive cycles have passed, the count restarts. The level changes only FILT_LEN cycles after the last reversal has settled.
- R5: On a selected edge of `level_o`, `pulse_o` for that line is high for exactly one cycle, one edge after the level change.
- R6: An edge of `level_o` in the direction not selected produces no strobe.
- R7: `stretch_o` rises together with `pulse_o` and stays high for exactly STRETCH_LEN cycles.
- R8: A new strobe that arrives while `stretch_o` is high reloads the stretch count. The output then stays high for STRETCH_LEN cycles counted from the new strobe.
- R9: Activity on one line has no effect on the outputs of any other line.
- R10: With EDGE = EDGE_FALL (encoding 1 of `ain_edge_e`; EDGE_RISE is 0), strobes fire on 1-to-0 transitions of the filtered level only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_i | input | N_LINES | Asynchronous input lines |
| level_o | output | N_LINES | Synchronized and deglitched level per line |
| pulse_o | output | N_LINES | One-cycle strobe on the selected edge per line |
| stretch_o | output | N_LINES | Strobe extended to STRETCH_LEN cycles per line |

## Verification
The bench builds two instances. The first has four lines, three synchronizer stages, a filter of three cycles, a stretch of twelve cycles and rising-edge strobes. Because its stretch is longer than a full fall-and-rise cycle of the filter, a second strobe can land inside an active stretch, which exercises the reload. Its filter of three also leaves room for sub-threshold glitches and for a reversal partway through a count. The second instance has two synchronizer stages, a filter of one cycle, a stretch of two cycles and falling-edge strobes. It covers the bypass variant of the filter, the shortest legal synchronizer and the opposite edge choice.

// File: rtl/async_in_cond_pkg.sv
package async_in_cond_pkg;
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } ain_edge_e;
endpackage

// File: rtl/ain_sync.sv
module ain_sync #(
   parameter int STAGES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ain_deglitch.sv
module ain_deglitch #(
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (FILT_LEN == 1) begin : g_bypass
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= d;
         end
      end else begin : g_count
         localparam int CW = $clog2(FILT_LEN);
         localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);
         logic [CW-1:0] run;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q   <= 1'b0;
               run <= '0;
            end else if (d == q) begin
               run <= '0;
            end else if (run == LAST) begin
               q   <= d;
               run <= '0;
            end else begin
               run <= run + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ain_pulse.sv
module ain_pulse
   import async_in_cond_pkg::*;
#(
   parameter ain_edge_e EDGE        = EDGE_RISE,
   parameter int        STRETCH_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse,
   output logic stretch
);
   localparam int SCW = $clog2(STRETCH_LEN + 1);
   localparam logic [SCW-1:0] RELOAD = SCW'(STRETCH_LEN);

   logic           lvl_q;
   logic           hit;
   logic [SCW-1:0] remain;

   generate
      if (EDGE == EDGE_RISE) begin : g_rise
         assign hit = lvl & ~lvl_q;
      end else begin : g_fall
         assign hit = ~lvl & lvl_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         pulse  <= 1'b0;
         remain <= '0;
      end else begin
         lvl_q <= lvl;
         pulse <= hit;
         if (hit)              remain <= RELOAD;
         else if (remain != 0) remain <= remain - 1'b1;
      end
   end

   assign stretch = (remain != '0);
endmodule

// File: rtl/async_in_cond.sv
module async_in_cond
   import async_in_cond_pkg::*;
#(
   parameter int        N_LINES     = 4,
   parameter int        SYNC_STAGES = 3,
   parameter int        FILT_LEN    = 4,
   parameter int        STRETCH_LEN = 8,
   parameter ain_edge_e EDGE        = EDGE_RISE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] raw_i,
   output logic [N_LINES-1:0] level_o,
   output logic [N_LINES-1:0] pulse_o,
   output logic [N_LINES-1:0] stretch_o
);
   if (N_LINES < 1) begin : g_bad_lines
      $error("async_in_cond: N_LINES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("async_in_cond: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("async_in_cond: FILT_LEN must be at least 1");
   end
   if (STRETCH_LEN < 1) begin : g_bad_stretch
      $error("async_in_cond: STRETCH_LEN must be at least 1");
   end

   logic [N_LINES-1:0] synced;

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         ain_sync #(
            .STAGES (SYNC_STAGES)
         ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_i[i]),
            .q     (synced[i])
         );

         ain_deglitch #(
            .FILT_LEN (FILT_LEN)
         ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (synced[i]),
            .q     (level_o[i])
         );

         ain_pulse #(
            .EDGE        (EDGE),
            .STRETCH_LEN (STRETCH_LEN)
         ) u_pulse (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (level_o[i]),
            .pulse   (pulse_o[i]),
            .stretch (stretch_o[i])
         );
      end
   endgenerate
endmodule

// File: rtl/async_in_cond_chk.sv
module async_in_cond_chk
   import async_in_cond_pkg::*;
#(
   parameter int        N_LINES     = 4,
   parameter int        FILT_LEN    = 4,
   parameter int        STRETCH_LEN = 8,
   parameter ain_edge_e EDGE        = EDGE_RISE
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_LINES-1:0] level_o,
   input logic [N_LINES-1:0] pulse_o,
   input logic [N_LINES-1:0] stretch_o
);
   // R1: a reset edge leaves every output low
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (level_o == '0 && pulse_o == '0 && stretch_o == '0));

   // R5: no strobe lasts two cycles
   a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_o != '0) |=> ((pulse_o & $past(pulse_o)) == '0));

   // R5/R6/R10: a strobe follows a level edge in the selected direction only
   generate
      if (EDGE == EDGE_RISE) begin : g_rise
         a_r6_edge_direction: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_o != '0) |->
               ((pulse_o & ~($past(level_o) & ~$past(level_o, 2))) == '0));
      end else begin : g_fall
         a_r10_edge_direction: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_o != '0) |->
               ((pulse_o & ~(~$past(level_o) & $past(level_o, 2))) == '0));
      end

      // R3: with a filter of two or more, the level never toggles two cycles in a row
      if (FILT_LEN >= 2) begin : g_filt
         a_r3_no_back_to_back_level: assert property (@(posedge clk) disable iff (!rst_n)
            (((level_o ^ $past(level_o)) & ($past(level_o) ^ $past(level_o, 2))) == '0));
      end

      // R8: the stretch cannot end in the cycle right after a strobe
      if (STRETCH_LEN >= 2) begin : g_str
         a_r8_no_drop_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            ((~stretch_o & $past(stretch_o) & $past(pulse_o)) == '0));
      end
   endgenerate

   // R7: a strobe is always inside the stretch
   a_r7_pulse_inside_stretch: assert property (@(posedge clk) disable iff (!rst_n)
      ((pulse_o & ~stretch_o) == '0));
endmodule

bind async_in_cond async_in_cond_chk #(
   .N_LINES     (N_LINES),
   .FILT_LEN    (FILT_LEN),
   .STRETCH_LEN (STRETCH_LEN),
   .EDGE        (EDGE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .level_o   (level_o),
   .pulse_o   (pulse_o),
   .stretch_o (stretch_o)
);

// File: tb/sim_async_in_cond.sv
`timescale 1ns/1ps
module sim_async_in_cond;
   import async_in_cond_pkg::*;

   localparam int N0 = 4, SY0 = 3, F0 = 3, S0 = 12;
   localparam int N1 = 2, SY1 = 2, F1 = 1, S1 = 2;
   localparam int LAT0 = SY0 + F0;
   localparam int LAT1 = SY1 + F1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N0-1:0] raw0 = '0;
   logic [N1-1:0] raw1 = '0;
   logic [N0-1:0] lvl0, pls0, str0;
   logic [N1-1:0] lvl1, pls1, str1;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   async_in_cond #(
      .N_LINES(N0), .SYNC_STAGES(SY0), .FILT_LEN(F0), .STRETCH_LEN(S0), .EDGE(EDGE_RISE)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .raw_i(raw0),
      .level_o(lvl0), .pulse_o(pls0), .stretch_o(str0)
   );

   async_in_cond #(
      .N_LINES(N1), .SYNC_STAGES(SY1), .FILT_LEN(F1), .STRETCH_LEN(S1), .EDGE(EDGE_FALL)
   ) u1 (
      .clk(clk), .rst_n(rst_n), .raw_i(raw1),
      .level_o(lvl1), .pulse_o(pls1), .stretch_o(str1)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      raw0 = '1;
      raw1 = '1;
      step(5);
      chk("R1", "u0 outputs in reset", int'({lvl0, pls0, str0}), 0);
      chk("R1", "u1 outputs in reset", int'({lvl1, pls1, str1}), 0);
      raw0 = '0;
      raw1 = '0;
      step(4);
      rst_n = 1'b1;
      step(10);
      chk("R1", "u0 outputs after release", int'({lvl0, pls0, str0}), 0);
      chk("R1", "u1 outputs after release", int'({lvl1, pls1, str1}), 0);
   endtask

   task automatic t_latency();
      raw0[0] = 1'b1;
      step(LAT0 - 1);
      chk("R2", "level one edge early", int'(lvl0[0]), 0);
      step(1);
      chk("R2", "level at latency", int'(lvl0[0]), 1);
      chk("R5", "pulse not yet", int'(pls0[0]), 0);
      step(1);
      chk("R5", "pulse vector", int'(pls0), 1);
      chk("R7", "stretch rises with pulse", int'(str0[0]), 1);
      step(1);
      chk("R5", "pulse one cycle", int'(pls0[0]), 0);
      chk("R7", "stretch holds", int'(str0[0]), 1);
      step(S0 - 2);
      chk("R7", "stretch last cycle", int'(str0[0]), 1);
      step(1);
      chk("R7", "stretch ends", int'(str0[0]), 0);
      chk("R9", "other lines untouched", int'({lvl0[3:1], pls0[3:1], str0[3:1]}), 0);
   endtask

   task automatic t_fall_no_pulse();
      int seen = 0;
      raw0[0] = 1'b0;
      for (int i = 0; i < LAT0 + 6; i++) begin
         step(1);
         seen += int'(pls0[0]);
      end
      chk("R6", "falling edge strobes", seen, 0);
      chk("R2", "level back low", int'(lvl0[0]), 0);
   endtask

   task automatic t_glitch();
      int lv = 0, pc = 0;
      raw0[1] = 1'b1;
      for (int i = 0; i < F0 - 1; i++) begin
         step(1);
         lv += int'(lvl0[1]);
         pc += int'(pls0[1]);
      end
      raw0[1] = 1'b0;
      for (int i = 0; i < LAT0 + 8; i++) begin
         step(1);
         lv += int'(lvl0[1]);
         pc += int'(pls0[1]);
      end
      chk("R3", "glitch level cycles", lv, 0);
      chk("R3", "glitch strobes", pc, 0);
   endtask

   task automatic t_restart();
      raw0[2] = 1'b1;
      step(F0 - 1);
      raw0[2] = 1'b0;
      step(1);
      raw0[2] = 1'b1;
      step(LAT0 - 1);
      chk("R4", "level before full run", int'(lvl0[2]), 0);
      step(1);
      chk("R4", "level after full run", int'(lvl0[2]), 1);
      raw0[2] = 1'b0;
      step(LAT0 + S0 + 4);
      chk("R4", "line settled low", int'({lvl0[2], str0[2]}), 0);
   endtask

   task automatic t_retrig();
      int pc = 0;
      logic [31:0] pat = '0;
      logic [31:0] sv = '0;
      raw0[3] = 1'b1;
      for (int i = 1; i < 30; i++) begin
         step(1);
         pc += int'(pls0[3]);
         pat[i] = pls0[3];
         sv[i] = str0[3];
         if (i == 3) raw0[3] = 1'b0;
         if (i == 7) raw0[3] = 1'b1;
      end
      chk("R8", "strobe count", pc, 2);
      chk("R8", "strobes at 7 and 14", int'(pat[7] & pat[14]), 1);
      chk("R8", "stretch past first window", int'(sv[19]), 1);
      chk("R8", "stretch at reloaded end", int'(sv[25]), 1);
      chk("R8", "stretch ends after reload", int'(sv[26]), 0);
      raw0[3] = 1'b0;
      step(LAT0 + 4);
   endtask

   task automatic t_falling_mode();
      int pc = 0;
      raw1[0] = 1'b1;
      step(LAT1 - 1);
      chk("R10", "u1 level early", int'(lvl1[0]), 0);
      for (int i = 0; i < 4; i++) begin
         step(1);
         pc += int'(pls1[0]);
      end
      chk("R10", "u1 level high", int'(lvl1[0]), 1);
      chk("R10", "u1 no strobe on rise", pc, 0);
      raw1[0] = 1'b0;
      step(LAT1);
      chk("R10", "u1 level low", int'(lvl1[0]), 0);
      chk("R10", "u1 no strobe yet", int'(pls1[0]), 0);
      step(1);
      chk("R10", "u1 strobe on fall", int'(pls1), 1);
      step(1);
      chk("R10", "u1 strobe one cycle", int'(pls1[0]), 0);
      chk("R7", "u1 stretch second cycle", int'(str1[0]), 1);
      step(1);
      chk("R7", "u1 stretch ends", int'(str1[0]), 0);
      chk("R9", "u1 line 1 untouched", int'({lvl1[1], pls1[1], str1[1]}), 0);
   endtask

   initial begin
      t_reset();
      t_latency();
      t_fall_no_pulse();
      t_glitch();
      t_restart();
      t_retrig();
      t_falling_mode();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule